// File: doc/BRIEF.md
# FIFO Flag Offset Programming Controller

This block owns the four threshold registers that a pair of opposing FIFOs uses to raise their almost-full and almost-empty flags. One FIFO carries data from port A to port B, and the other carries data from port B to port A. Each FIFO has its own active-low master reset.

The levels on three configuration pins are captured on the last port A clock edge at which a reset is still low. That captured code selects one of three ways to fill the registers:

- **Fixed preset.** One fixed value goes into both registers of the FIFO being released.
- **Word load.** The first four accepted port A writes are taken as register values and are not stored.
- **Serial load.** A 40-bit stream is clocked in on one pin while an enable pin is held low.

The block drives the port A and port B input-ready flags and holds them low until programming completes. The port B flag is released through a two-stage synchronizer in the port B clock domain.

The surrounding FIFO uses `mem_wr` to decide which port A writes reach its RAM. It reads the four offsets as comparator thresholds.

Top module: `fifo_ofs_prog`

## Requirements
- R1: While `rst_ab_n` or `rst_ba_n` is low, `rdy_a` is low from the next `clk_a` edge and `mem_wr` stays low. Each FIFO's two offsets read 1 from the first `clk_a` edge inside its own reset.
- R2: Preset codes use the pins (`cfg_m`, `cfg_hi_sen_n`, `cfg_lo_sdat`):
  - 1,1,1 selects 64.
  - 1,1,0 selects 16.
  - 1,0,1 selects 8.

  The value appears in both registers of the released FIFO after the first `clk_a` edge with the reset high. `af_a_ofs` and `ae_b_ofs` belong to `rst_ab_n`; `ae_a_ofs` and `af_b_ofs` belong to `rst_ba_n`. `rdy_a` rises one edge later. An offset changes only on its own FIFO's release or during programming.
- R3: The codes 0,0,0, 0,0,1 and 0,1,1 are reserved. They load 8 like a preset and raise `cfg_err`. `cfg_err` clears when the same reset is asserted again.
- R4: Code 1,0,0 selects word load. `rdy_a` rises on the second `clk_a` edge after release. The first four writes with `wr_en` and `rdy_a` both high load `af_a_ofs`, `ae_b_ofs`, `af_b_ofs` and `ae_a_ofs`, in that order, from `wr_data[9:0]` with bit 9 as MSB. `mem_wr` stays low for these writes, and a write while `rdy_a` is low has no effect.
- R5: After the fourth programming word, a write with `wr_en` and `rdy_a` high drives `mem_wr` high in the same cycle.
- R6: Code 0,1,0 selects serial load. On every `clk_a` edge with `cfg_hi_sen_n` low, one bit is taken from `cfg_lo_sdat`. Forty bits fill `af_a_ofs`, `ae_b_ofs`, `af_b_ofs`, `ae_a_ofs` in that order, each MSB first. Edges with `cfg_hi_sen_n` high are ignored, and `rdy_a` stays low throughout.
- R7: In serial load, `rdy_a` is still low after the edge that takes the 40th bit and is high after the following `clk_a` edge.
- R8: A loaded value of 0 becomes 1, and a value above 1020 becomes 1020, for both load paths.
- R9: `rdy_b` rises two or more `clk_b` edges after programming completes. It is forced low asynchronously whenever either reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_ab_n | input | 1 | Master reset of the A-to-B FIFO, active low |
| rst_ba_n | input | 1 | Master reset of the B-to-A FIFO, active low |
| cfg_m | input | 1 | Mode select pin, sampled during reset |
| cfg_hi_sen_n | input | 1 | Mode select pin; serial enable (active low) after release |
| cfg_lo_sdat | input | 1 | Mode select pin; serial data after release |
| wr_en | input | 1 | Port A write strobe |
| wr_data | input | 36 | Port A write data |
| mem_wr | output | 1 | Write is passed to the FIFO RAM |
| rdy_a | output | 1 | Port A input-ready flag |
| rdy_b | output | 1 | Port B input-ready flag (clk_b domain) |
| cfg_err | output | 1 | A reserved mode code was captured |
| af_a_ofs | output | 10 | Port A almost-full offset (A-to-B FIFO) |
| ae_b_ofs | output | 10 | Port B almost-empty offset (A-to-B FIFO) |
| af_b_ofs | output | 10 | Port B almost-full offset (B-to-A FIFO) |
| ae_a_ofs | output | 10 | Port A almost-empty offset (B-to-A FIFO) |

## Verification
Word consumption and memory pass-through can fall on adjacent edges. The bench presents the fifth write in the cycle right after the fourth programming word and expects `mem_wr` high there. It expects `mem_wr` low on every earlier write, including one offered while `rdy_a` is still low.

A second collision comes from a release of the B-to-A reset alone while the A-to-B registers hold serially loaded values. The bench judges that case by checking that the preset lands only in `af_b_ofs` and `ae_a_ofs` and that `rdy_b` drops at once.

// File: rtl/fifo_ofs_pkg.sv
`timescale 1ns/100ps
package fifo_ofs_pkg;

    // Decoded programming mode captured while a master reset is low.
    typedef enum logic [2:0] {
        MD_P64 = 3'd0,
        MD_P16 = 3'd1,
        MD_P8  = 3'd2,
        MD_WRD = 3'd3,
        MD_SER = 3'd4,
        MD_RSV = 3'd5
    } ofs_mode_e;

    function automatic ofs_mode_e decode_pins(input logic m, input logic hi, input logic lo);
        ofs_mode_e r;
        case ({m, hi, lo})
            3'b111:  r = MD_P64;
            3'b110:  r = MD_P16;
            3'b101:  r = MD_P8;
            3'b100:  r = MD_WRD;
            3'b010:  r = MD_SER;
            default: r = MD_RSV;
        endcase
        return r;
    endfunction

    function automatic logic is_sequenced(input ofs_mode_e md);
        return (md == MD_WRD) || (md == MD_SER);
    endfunction

endpackage

// File: rtl/fifo_ofs_decode.sv
`timescale 1ns/100ps
module fifo_ofs_decode
    import fifo_ofs_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic             cfg_m,
    input  logic             cfg_hi,
    input  logic             cfg_lo,
    output ofs_mode_e        mode,
    output logic [OFS_W-1:0] preset_val
);
    localparam logic [OFS_W-1:0] PV64 = OFS_W'(64);
    localparam logic [OFS_W-1:0] PV16 = OFS_W'(16);
    localparam logic [OFS_W-1:0] PV8  = OFS_W'(8);

    always_comb begin
        mode = decode_pins(cfg_m, cfg_hi, cfg_lo);
        case (mode)
            MD_P64:  preset_val = PV64;
            MD_P16:  preset_val = PV16;
            default: preset_val = PV8;   // P8, reserved fallback, unused for sequenced modes
        endcase
    end

    // R3: reserved codes always fall back to the smallest preset
    always_comb begin
        if (mode == MD_RSV)
            p_rsv_falls_to_8_r3: assert (preset_val == PV8);
    end

endmodule

// File: rtl/fifo_ofs_seq.sv
`timescale 1ns/100ps
module fifo_ofs_seq
    import fifo_ofs_pkg::*;
#(
    parameter int OFS_W   = 10,
    parameter int MAX_OFS = 1020,
    parameter int NREG    = 4
) (
    input  logic                       clk,
    input  logic                       rst_ab_n,
    input  logic                       rst_ba_n,
    input  ofs_mode_e                  pin_mode,
    input  logic [OFS_W-1:0]           pin_preset,
    input  logic                       ser_en_n,
    input  logic                       ser_dat,
    input  logic                       wr_en,
    input  logic [OFS_W-1:0]           wr_val,
    output logic                       mem_wr,
    output logic                       rdy_a,
    output logic                       done,
    output logic                       cfg_err,
    output logic [NREG-1:0][OFS_W-1:0] ofs
);
    localparam int IDX_W = $clog2(NREG);
    localparam int BC_W  = $clog2(OFS_W);
    localparam logic [OFS_W-1:0] MAXV   = OFS_W'(MAX_OFS);
    localparam logic [OFS_W-1:0] MINV   = OFS_W'(1);
    localparam logic [IDX_W-1:0] LASTW  = IDX_W'(NREG - 1);
    localparam logic [BC_W-1:0]  LASTB  = BC_W'(OFS_W - 1);

    typedef struct packed {
        ofs_mode_e                  md1;
        ofs_mode_e                  md2;
        logic [OFS_W-1:0]           pv1;
        logic [OFS_W-1:0]           pv2;
        logic                       r1;
        logic                       r2;
        logic                       err1;
        logic                       err2;
        logic                       pend;
        logic                       done;
        logic                       rdy;
        logic [IDX_W-1:0]           widx;
        logic [BC_W-1:0]            bcnt;
        logic [OFS_W-1:0]           sh;
        logic [NREG-1:0][OFS_W-1:0] ofs;
    } st_t;

    st_t s_q, s_d;

    function automatic logic [OFS_W-1:0] clamp(input logic [OFS_W-1:0] v);
        if (v == '0)       return MINV;
        else if (v > MAXV) return MAXV;
        else               return v;
    endfunction

    logic both_up, rel1, rel2;
    logic [OFS_W-1:0] ser_word;

    always_comb begin
        both_up  = rst_ab_n && rst_ba_n;
        rel1     = rst_ab_n && !s_q.r1;
        rel2     = rst_ba_n && !s_q.r2;
        ser_word = {s_q.sh[OFS_W-2:0], ser_dat};

        s_d    = s_q;
        s_d.r1 = rst_ab_n;
        s_d.r2 = rst_ba_n;

        // A-to-B FIFO: registers 0 (port A almost-full) and 1 (port B almost-empty)
        if (!rst_ab_n) begin
            s_d.md1    = pin_mode;
            s_d.pv1    = pin_preset;
            s_d.err1   = 1'b0;
            s_d.pend   = 1'b0;
            s_d.widx   = '0;
            s_d.bcnt   = '0;
            s_d.ofs[0] = MINV;
            s_d.ofs[1] = MINV;
        end else if (rel1) begin
            s_d.err1 = (s_q.md1 == MD_RSV);
            if (is_sequenced(s_q.md1)) begin
                s_d.pend = 1'b1;
            end else begin
                s_d.ofs[0] = s_q.pv1;
                s_d.ofs[1] = s_q.pv1;
            end
        end

        // B-to-A FIFO: registers 2 (port B almost-full) and 3 (port A almost-empty)
        if (!rst_ba_n) begin
            s_d.md2    = pin_mode;
            s_d.pv2    = pin_preset;
            s_d.err2   = 1'b0;
            s_d.ofs[2] = MINV;
            s_d.ofs[3] = MINV;
        end else if (rel2) begin
            s_d.err2 = (s_q.md2 == MD_RSV);
            if (!is_sequenced(s_q.md2)) begin
                s_d.ofs[2] = s_q.pv2;
                s_d.ofs[3] = s_q.pv2;
            end
        end

        // Programming sequence, fixed register order 0,1,2,3
        if (s_q.pend && both_up) begin
            if (s_q.md1 == MD_WRD && wr_en && s_q.rdy) begin
                s_d.ofs[s_q.widx] = clamp(wr_val);
                s_d.widx          = s_q.widx + 1'b1;
                if (s_q.widx == LASTW) s_d.pend = 1'b0;
            end else if (s_q.md1 == MD_SER && !ser_en_n) begin
                s_d.sh = ser_word;
                if (s_q.bcnt == LASTB) begin
                    s_d.bcnt          = '0;
                    s_d.ofs[s_q.widx] = clamp(ser_word);
                    s_d.widx          = s_q.widx + 1'b1;
                    if (s_q.widx == LASTW) s_d.pend = 1'b0;
                end else begin
                    s_d.bcnt = s_q.bcnt + 1'b1;
                end
            end
        end

        s_d.done = both_up && !s_d.pend;
        s_d.rdy  = both_up && (s_q.done || (s_q.pend && s_q.md1 == MD_WRD));
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign mem_wr  = wr_en && s_q.rdy && !s_q.pend && rst_ab_n && rst_ba_n;
    assign rdy_a   = s_q.rdy;
    assign done    = s_q.done;
    assign cfg_err = s_q.err1 || s_q.err2;
    assign ofs     = s_q.ofs;

    // R8: every offset stays in the legal window once both FIFOs run
    for (genvar g = 0; g < NREG; g++) begin : g_rng
        p_ofs_in_window_r8: assert property (@(posedge clk) disable iff (!rst_ab_n || !rst_ba_n)
            (s_q.ofs[g] >= MINV) && (s_q.ofs[g] <= MAXV));
    end

    // R6: serial bit counter never leaves one register width
    p_bitcnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_ab_n)
        s_q.bcnt <= LASTB);

    // R6: port A stays not-ready while serial bits are pending
    p_ser_holds_rdy_r6: assert property (@(posedge clk) disable iff (!rst_ab_n || !rst_ba_n)
        (s_q.pend && s_q.md1 == MD_SER) |-> !rdy_a);

    // R7: port A ready follows serial completion by one edge
    p_ser_rdy_rise_r7: assert property (@(posedge clk) disable iff (!rst_ab_n || !rst_ba_n)
        ($rose(s_q.done) && s_q.md1 == MD_SER) |=> rdy_a);

    // R2: A-to-B offsets hold once programming is complete
    p_fifo1_hold_r2: assert property (@(posedge clk) disable iff (!rst_ab_n)
        s_q.done |=> $stable(s_q.ofs[1:0]));

endmodule

// File: rtl/fifo_ofs_sync.sv
`timescale 1ns/100ps
module fifo_ofs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];

    // R9: output can only rise after the first stage already held a one
    p_sync_order_r9: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(q) |-> $past(sh_q[STAGES-2]));

endmodule

// File: rtl/fifo_ofs_prog.sv
`timescale 1ns/100ps
module fifo_ofs_prog
    import fifo_ofs_pkg::*;
#(
    parameter int DEPTH      = 1024,
    parameter int MARGIN     = 4,
    parameter int WORD_W     = 36,
    parameter int SYNC_STAGE = 2
) (
    input  logic                      clk_a,
    input  logic                      clk_b,
    input  logic                      rst_ab_n,
    input  logic                      rst_ba_n,
    input  logic                      cfg_m,
    input  logic                      cfg_hi_sen_n,
    input  logic                      cfg_lo_sdat,
    input  logic                      wr_en,
    input  logic [WORD_W-1:0]         wr_data,
    output logic                      mem_wr,
    output logic                      rdy_a,
    output logic                      rdy_b,
    output logic                      cfg_err,
    output logic [$clog2(DEPTH)-1:0]  af_a_ofs,
    output logic [$clog2(DEPTH)-1:0]  ae_b_ofs,
    output logic [$clog2(DEPTH)-1:0]  af_b_ofs,
    output logic [$clog2(DEPTH)-1:0]  ae_a_ofs
);
    localparam int OFS_W   = $clog2(DEPTH);
    localparam int MAX_OFS = DEPTH - MARGIN;
    localparam int NREG    = 4;

    ofs_mode_e                  pin_mode;
    logic [OFS_W-1:0]           pin_preset;
    logic                       done_a;
    logic                       both_rst_n;
    logic [NREG-1:0][OFS_W-1:0] ofs;
    logic                       unused_hi_bits;

    assign unused_hi_bits = ^wr_data[WORD_W-1:OFS_W];
    assign both_rst_n     = rst_ab_n & rst_ba_n;

    fifo_ofs_decode #(.OFS_W(OFS_W)) u_dec (
        .cfg_m      (cfg_m),
        .cfg_hi     (cfg_hi_sen_n),
        .cfg_lo     (cfg_lo_sdat),
        .mode       (pin_mode),
        .preset_val (pin_preset)
    );

    fifo_ofs_seq #(.OFS_W(OFS_W), .MAX_OFS(MAX_OFS), .NREG(NREG)) u_seq (
        .clk        (clk_a),
        .rst_ab_n   (rst_ab_n),
        .rst_ba_n   (rst_ba_n),
        .pin_mode   (pin_mode),
        .pin_preset (pin_preset),
        .ser_en_n   (cfg_hi_sen_n),
        .ser_dat    (cfg_lo_sdat),
        .wr_en      (wr_en),
        .wr_val     (wr_data[OFS_W-1:0]),
        .mem_wr     (mem_wr),
        .rdy_a      (rdy_a),
        .done       (done_a),
        .cfg_err    (cfg_err),
        .ofs        (ofs)
    );

    fifo_ofs_sync #(.STAGES(SYNC_STAGE)) u_sync_b (
        .clk    (clk_b),
        .arst_n (both_rst_n),
        .d      (done_a),
        .q      (rdy_b)
    );

    assign af_a_ofs = ofs[0];
    assign ae_b_ofs = ofs[1];
    assign af_b_ofs = ofs[2];
    assign ae_a_ofs = ofs[3];

endmodule

// File: tb/fifo_ofs_prog_test.sv
`timescale 1ns/100ps
module fifo_ofs_prog_test;
    localparam int W = 10;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_ab_n = 1'b0, rst_ba_n = 1'b0;
    logic cfg_m = 1'b0, cfg_hi_sen_n = 1'b1, cfg_lo_sdat = 1'b0;
    logic wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic mem_wr, rdy_a, rdy_b, cfg_err;
    logic [W-1:0] af_a_ofs, ae_b_ofs, af_b_ofs, ae_a_ofs;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    fifo_ofs_prog uut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_ab_n(rst_ab_n), .rst_ba_n(rst_ba_n),
        .cfg_m(cfg_m), .cfg_hi_sen_n(cfg_hi_sen_n), .cfg_lo_sdat(cfg_lo_sdat),
        .wr_en(wr_en), .wr_data(wr_data), .mem_wr(mem_wr), .rdy_a(rdy_a),
        .rdy_b(rdy_b), .cfg_err(cfg_err), .af_a_ofs(af_a_ofs), .ae_b_ofs(ae_b_ofs),
        .af_b_ofs(af_b_ofs), .ae_a_ofs(ae_a_ofs)
    );

    always #5   clk_a = ~clk_a;
    always #6.5 clk_b = ~clk_b;

    typedef struct packed {
        logic         m;
        logic         hi;
        logic         lo;
        logic [W-1:0] val;
        logic         err;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b1, 1'b1, 1'b1, 10'd64, 1'b0},
        '{1'b0, 1'b0, 1'b0, 10'd8,  1'b1},
        '{1'b1, 1'b1, 1'b0, 10'd16, 1'b0},
        '{1'b0, 1'b0, 1'b1, 10'd8,  1'b1},
        '{1'b1, 1'b0, 1'b1, 10'd8,  1'b0},
        '{1'b0, 1'b1, 1'b1, 10'd8,  1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_ofs(input string req, input int a, input int b, input int c, input int d);
        chk({req, " af_a"}, 32'(af_a_ofs), 32'(a));
        chk({req, " ae_b"}, 32'(ae_b_ofs), 32'(b));
        chk({req, " af_b"}, 32'(af_b_ofs), 32'(c));
        chk({req, " ae_a"}, 32'(ae_a_ofs), 32'(d));
    endtask

    // Both resets low with a mode code; ends at the negedge after the release edge.
    task automatic reset_both(input logic m, input logic hi, input logic lo);
        @(negedge clk_a);
        rst_ab_n = 1'b0; rst_ba_n = 1'b0;
        cfg_m = m; cfg_hi_sen_n = hi; cfg_lo_sdat = lo;
        wr_en = 1'b1;
        #1 chk("R9 rdy_b async low", 32'(rdy_b), 0);
        repeat (2) @(negedge clk_a);
        chk("R1 rdy_a low in reset", 32'(rdy_a), 0);
        chk("R1 mem_wr low in reset", 32'(mem_wr), 0);
        chk_ofs("R1 reset value", 1, 1, 1, 1);
        wr_en = 1'b0;
        rst_ab_n = 1'b1; rst_ba_n = 1'b1;
        @(negedge clk_a);
    endtask

    task automatic port_write(input logic [W-1:0] v);
        wr_en = 1'b1;
        wr_data = {26'h2AB_CDEF, v};
    endtask

    initial begin
        // Table walk: preset and reserved codes
        foreach (VEC[i]) begin
            reset_both(VEC[i].m, VEC[i].hi, VEC[i].lo);
            chk_ofs(VEC[i].err ? "R3 reserved load" : "R2 preset load",
                    VEC[i].val, VEC[i].val, VEC[i].val, VEC[i].val);
            chk("R3 cfg_err", 32'(cfg_err), 32'(VEC[i].err));
            chk("R2 rdy_a still low", 32'(rdy_a), 0);
            @(negedge clk_a);
            chk("R2 rdy_a up", 32'(rdy_a), 1);
            repeat (4) @(negedge clk_a);
            chk("R9 rdy_b up", 32'(rdy_b), 1);
        end

        // Word load from port A
        reset_both(1'b1, 1'b0, 1'b0);
        chk("R4 rdy_a low after release", 32'(rdy_a), 0);
        port_write(10'd77);                   // dropped: rdy_a still low
        @(negedge clk_a);
        chk("R4 rdy_a up", 32'(rdy_a), 1);
        chk("R4 af_a untouched by dropped write", 32'(af_a_ofs), 1);
        port_write(10'd0);
        chk("R4 mem_wr low word0", 32'(mem_wr), 0);
        @(negedge clk_a);
        port_write(10'd1023);
        chk("R4 mem_wr low word1", 32'(mem_wr), 0);
        @(negedge clk_a);
        port_write(10'd300);
        chk("R4 mem_wr low word2", 32'(mem_wr), 0);
        @(negedge clk_a);
        port_write(10'd517);
        chk("R4 mem_wr low word3", 32'(mem_wr), 0);
        chk("R9 rdy_b low while programming", 32'(rdy_b), 0);
        @(negedge clk_a);
        chk_ofs("R4 R8 word order and clamp", 1, 1020, 300, 517);
        port_write(10'd9);
        chk("R5 mem_wr on fifth write", 32'(mem_wr), 1);
        chk("R5 rdy_b not yet synced", 32'(rdy_b), 0);
        @(negedge clk_a);
        wr_en = 1'b0;
        chk("R5 offsets unchanged by stored write", 32'(af_a_ofs), 1);
        repeat (4) @(negedge clk_a);
        chk("R9 rdy_b after word load", 32'(rdy_b), 1);

        // Serial load
        reset_both(1'b0, 1'b1, 1'b0);
        begin
            logic [3:0][W-1:0] sv;
            sv = {10'd700, 10'd1023, 10'd0, 10'd5};   // index 0 is sent first
            for (int w = 0; w < 4; w++) begin
                for (int b = W - 1; b >= 0; b--) begin
                    cfg_hi_sen_n = 1'b0;
                    cfg_lo_sdat  = sv[w][b];
                    @(negedge clk_a);
                    if (w == 1 && b == 5) begin       // idle edge with garbage data
                        cfg_hi_sen_n = 1'b1;
                        cfg_lo_sdat  = 1'b1;
                        @(negedge clk_a);
                        chk("R6 rdy_a low mid stream", 32'(rdy_a), 0);
                    end
                end
            end
        end
        cfg_hi_sen_n = 1'b1;
        chk_ofs("R6 R8 serial order and clamp", 5, 1, 1020, 700);
        chk("R7 rdy_a low after last bit", 32'(rdy_a), 0);
        chk("R9 rdy_b low after last bit", 32'(rdy_b), 0);
        @(negedge clk_a);
        chk("R7 rdy_a up one edge later", 32'(rdy_a), 1);
        repeat (4) @(negedge clk_a);
        chk("R9 rdy_b after serial", 32'(rdy_b), 1);

        // Reset of the B-to-A FIFO alone with preset 64
        rst_ba_n = 1'b0;
        cfg_m = 1'b1; cfg_hi_sen_n = 1'b1; cfg_lo_sdat = 1'b1;
        #1 chk("R9 rdy_b async low on B-to-A reset", 32'(rdy_b), 0);
        @(negedge clk_a);
        chk("R1 rdy_a low on B-to-A reset", 32'(rdy_a), 0);
        chk_ofs("R1 only B-to-A cleared", 5, 1, 1, 1);
        rst_ba_n = 1'b1;
        @(negedge clk_a);
        chk_ofs("R2 preset only in B-to-A", 5, 1, 64, 64);
        @(negedge clk_a);
        chk("R2 rdy_a up after B-to-A release", 32'(rdy_a), 1);
        repeat (4) @(negedge clk_a);
        chk("R9 rdy_b back up", 32'(rdy_b), 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule